// File: doc/BRIEF.md
# Multi-Rate Speed Switch Sequencer

This block controls a change of line speed on a multi-rate Ethernet PHY. It takes a new speed either from a register write or from an auto-negotiation result. It then sorts that speed into a rate group: the low group holds 10M, 100M and 1G, and 2.5G and 10G each form a group of their own. The low group runs over a 1.25 Gbps serial line. 2.5G needs 3.125 Gbps and 10G needs 10.3125 Gbps, so moving between groups means retuning the transceiver.

A change that stays inside the current group only updates the speed select. A change that crosses groups cannot be made while traffic flows. The sequencer first asks the datapath to stop traffic. It then issues a one-cycle reconfiguration request to an external transceiver reconfiguration agent and waits for its acknowledge. After that it holds the PHY in reset for a programmable time and finally applies the new speed select.

The state machine has six states: IDLE, DRAIN, RECONFIG_REQ, RECONFIG_WAIT, PHY_RESET and DONE. Its transitions are:
- IDLE→DONE when an accepted request targets the same group.
- IDLE→DRAIN when an accepted request targets another group.
- DRAIN→RECONFIG_REQ once the datapath reports that it is idle.
- RECONFIG_REQ→RECONFIG_WAIT always, after one cycle.
- RECONFIG_WAIT→PHY_RESET when the acknowledge arrives.
- RECONFIG_WAIT→DONE when the acknowledge timeout expires.
- PHY_RESET→DONE when the reset window ends.
- DONE→IDLE always, after one cycle.

Top module: `rate_switch_seq`

## Requirements
- R1: After reset, `speed_sel` holds the 1G code (2), and `busy`, `done`, `drain_req`, `xcvr_cfg_req`, `phy_rst` and `cfg_error` are all low.
- R2: Speed codes are 0=10M, 1=100M, 2=1G, 3=2.5G and 4=10G. A request that carries a code of 5 or more is ignored: `busy` stays low and `speed_sel` does not change.
- R3: A request for the speed that is already selected completes with `done` high in the cycle after it is presented. It causes no drain, no reconfiguration request and no PHY reset.
- R4: A request for another speed in the same group completes with `done` high in the cycle after it is presented, and `speed_sel` shows the new code in that same cycle. No drain, no reconfiguration request and no PHY reset occur.
- R5: A valid register request and a valid auto-negotiation request may arrive in the same cycle. The register request is taken. An auto-negotiation request on its own is acted on like a register request.
- R6: A cross-group request raises `drain_req` in the next cycle. No reconfiguration request is issued while `traffic_idle` is low.
- R7: The reconfiguration request is a single-cycle pulse. While it is high, `xcvr_cfg_rate` carries the target group: 0=1.25 Gbps group, 1=2.5G, 2=10G.
- R8: After the acknowledge, `phy_rst` is high for exactly max(`rst_len`, 8) consecutive cycles, and `drain_req` stays high throughout.
- R9: `speed_sel` changes only in a cycle where `done` is high. After a successful cross-group sequence it holds the target code, and `drain_req` is low in the DONE cycle.
- R10: `busy` is high from the cycle after a request is accepted through the DONE cycle. Any request presented while `busy` is high is ignored.
- R11: If no acknowledge arrives within ACK_TIMEOUT (64) cycles of waiting, `cfg_error` rises together with `done`. In that case `phy_rst` is never raised and `speed_sel` is unchanged. The next accepted request clears `cfg_error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req_valid | input | 1 | Register-write speed request strobe |
| reg_req_speed | input | 3 | Register-write speed code |
| an_req_valid | input | 1 | Auto-negotiation speed request strobe |
| an_req_speed | input | 3 | Auto-negotiation speed code |
| traffic_idle | input | 1 | Datapath reports that traffic has stopped |
| xcvr_cfg_ack | input | 1 | Transceiver reconfiguration finished |
| rst_len | input | 8 | Requested PHY reset length in cycles (floor 8) |
| drain_req | output | 1 | Ask the datapath to stop traffic |
| xcvr_cfg_req | output | 1 | One-cycle transceiver reconfiguration request |
| xcvr_cfg_rate | output | 2 | Target rate group for reconfiguration |
| phy_rst | output | 1 | PHY reset pulse |
| speed_sel | output | 3 | Active speed code |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finishing this cycle |
| cfg_error | output | 1 | Reconfiguration acknowledge timed out |

## Verification
The main function is exercised with three kinds of request:
- Same-speed and in-group requests show that the short path skips the drain, reconfiguration and reset stages entirely.
- Cross-group requests upward to 10G and downward to 2.5G use different acknowledge delays and reset lengths, one below the floor and one above it. They confirm the group code that is sent and the exact length of the reset window.
- A request whose acknowledge never arrives separates the timeout exit from the normal exit.

Traffic that stays busy for several cycles shows that the drain wait really gates the reconfiguration request. Competing and mid-sequence requests show the source priority and the lockout while busy.

// File: rtl/rate_switch_pkg.sv
package rate_switch_pkg;

    typedef enum logic [2:0] {
        SPD_10M  = 3'd0,
        SPD_100M = 3'd1,
        SPD_1G   = 3'd2,
        SPD_2G5  = 3'd3,
        SPD_10G  = 3'd4
    } speed_code_e;

    typedef enum logic [1:0] {
        GRP_LOW = 2'd0,
        GRP_2G5 = 2'd1,
        GRP_10G = 2'd2
    } rate_group_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DRAIN,
        S_RECONFIG_REQ,
        S_RECONFIG_WAIT,
        S_PHY_RESET,
        S_DONE
    } seq_state_e;

    localparam int unsigned SPEED_W = 3;
    localparam int unsigned GROUP_W = 2;

endpackage

// File: rtl/rate_group_map.sv
module rate_group_map
    import rate_switch_pkg::*;
(
    input  logic [SPEED_W-1:0] speed,
    output logic               legal,
    output logic [GROUP_W-1:0] group
);
    always_comb begin
        legal = 1'b1;
        group = GRP_LOW;
        unique case (speed)
            SPD_10M, SPD_100M, SPD_1G: group = GRP_LOW;
            SPD_2G5:                   group = GRP_2G5;
            SPD_10G:                   group = GRP_10G;
            default:                   legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/rate_cycle_window.sv
// Counts consecutive cycles while run is high; hit marks the last cycle of a
// window of 'limit' cycles. The count clears as soon as run drops.
module rate_cycle_window #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_q;

    assign hit = run && (cnt_q == limit - W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (run && !hit)
            cnt_q <= cnt_q + W'(1);
        else
            cnt_q <= '0;
    end
endmodule

// File: rtl/rate_switch_seq.sv
module rate_switch_seq
    import rate_switch_pkg::*;
#(
    parameter int unsigned RST_LEN_W   = 8,
    parameter int unsigned MIN_RST     = 8,
    parameter int unsigned ACK_TIMEOUT = 64,
    parameter logic [2:0]  INIT_SPEED  = 3'd2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_req_valid,
    input  logic [2:0] reg_req_speed,
    input  logic       an_req_valid,
    input  logic [2:0] an_req_speed,
    input  logic       traffic_idle,
    input  logic       xcvr_cfg_ack,
    input  logic [7:0] rst_len,
    output logic       drain_req,
    output logic       xcvr_cfg_req,
    output logic [1:0] xcvr_cfg_rate,
    output logic       phy_rst,
    output logic [2:0] speed_sel,
    output logic       busy,
    output logic       done,
    output logic       cfg_error
);
    localparam int unsigned TO_W = $clog2(ACK_TIMEOUT + 1);

    seq_state_e         state_q, state_d;
    logic [SPEED_W-1:0] target_q, speed_q;
    logic               err_q;

    logic               reg_legal, an_legal, cur_legal;
    logic [GROUP_W-1:0] reg_grp, an_grp, cur_grp;
    logic [GROUP_W-1:0] tgt_grp;
    logic               tgt_legal_unused;

    logic               accept;
    logic [SPEED_W-1:0] pick_speed;
    logic [GROUP_W-1:0] pick_grp;

    logic [RST_LEN_W-1:0] rst_eff;
    logic               rst_hit, wd_hit, go_err;

    // group lookups: two request sources, the active speed and the latched target
    rate_group_map u_map_reg (.speed(reg_req_speed), .legal(reg_legal), .group(reg_grp));
    rate_group_map u_map_an  (.speed(an_req_speed),  .legal(an_legal),  .group(an_grp));
    rate_group_map u_map_cur (.speed(speed_q),       .legal(cur_legal), .group(cur_grp));
    rate_group_map u_map_tgt (.speed(target_q),      .legal(tgt_legal_unused), .group(tgt_grp));

    // request arbitration: register source wins over auto-negotiation
    always_comb begin
        accept     = 1'b0;
        pick_speed = speed_q;
        pick_grp   = cur_grp;
        if (state_q == S_IDLE) begin
            if (reg_req_valid && reg_legal) begin
                accept     = 1'b1;
                pick_speed = reg_req_speed;
                pick_grp   = reg_grp;
            end else if (an_req_valid && an_legal) begin
                accept     = 1'b1;
                pick_speed = an_req_speed;
                pick_grp   = an_grp;
            end
        end
    end

    assign rst_eff = (rst_len < RST_LEN_W'(MIN_RST)) ? RST_LEN_W'(MIN_RST) : rst_len;

    rate_cycle_window #(.W(RST_LEN_W)) u_rst_window (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == S_PHY_RESET),
        .limit (rst_eff),
        .hit   (rst_hit)
    );

    rate_cycle_window #(.W(TO_W)) u_ack_watchdog (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == S_RECONFIG_WAIT),
        .limit (TO_W'(ACK_TIMEOUT)),
        .hit   (wd_hit)
    );

    assign go_err = (state_q == S_RECONFIG_WAIT) && !xcvr_cfg_ack && wd_hit;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:          if (accept) state_d = (pick_grp == cur_grp) ? S_DONE : S_DRAIN;
            S_DRAIN:         if (traffic_idle) state_d = S_RECONFIG_REQ;
            S_RECONFIG_REQ:  state_d = S_RECONFIG_WAIT;
            S_RECONFIG_WAIT: if (xcvr_cfg_ack) state_d = S_PHY_RESET;
                             else if (wd_hit) state_d = S_DONE;
            S_PHY_RESET:     if (rst_hit) state_d = S_DONE;
            S_DONE:          state_d = S_IDLE;
            default:         state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // request target, active speed and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= INIT_SPEED;
            speed_q  <= INIT_SPEED;
            err_q    <= 1'b0;
        end else begin
            if (accept) begin
                target_q <= pick_speed;
                err_q    <= 1'b0;
                if (pick_grp == cur_grp) speed_q <= pick_speed;
            end else if (go_err) begin
                err_q <= 1'b1;
            end else if (state_q == S_PHY_RESET && rst_hit) begin
                speed_q <= target_q;
            end
        end
    end

    // outputs
    always_comb begin
        drain_req     = 1'b0;
        xcvr_cfg_req  = 1'b0;
        phy_rst       = 1'b0;
        busy          = 1'b1;
        done          = 1'b0;
        xcvr_cfg_rate = tgt_grp;
        unique case (state_q)
            S_IDLE:          busy = 1'b0;
            S_DRAIN:         drain_req = 1'b1;
            S_RECONFIG_REQ:  begin drain_req = 1'b1; xcvr_cfg_req = 1'b1; end
            S_RECONFIG_WAIT: drain_req = 1'b1;
            S_PHY_RESET:     begin drain_req = 1'b1; phy_rst = 1'b1; end
            S_DONE:          done = 1'b1;
            default:         busy = 1'b0;
        endcase
    end

    assign speed_sel = speed_q;
    assign cfg_error = err_q;

endmodule

// File: rtl/rate_switch_seq_checker.sv
module rate_switch_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       drain_req,
    input logic       xcvr_cfg_req,
    input logic       traffic_idle,
    input logic       phy_rst,
    input logic [2:0] speed_sel,
    input logic       busy,
    input logic       done,
    input logic       cfg_error
);
    logic [15:0] rst_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       rst_run_q <= '0;
        else if (phy_rst) rst_run_q <= rst_run_q + 16'd1;
        else              rst_run_q <= '0;
    end

    assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        speed_sel <= 3'd4);

    assert_cfg_after_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xcvr_cfg_req) |-> $past(traffic_idle));

    assert_cfg_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_cfg_req |=> !xcvr_cfg_req);

    assert_rst_under_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        phy_rst |-> drain_req);

    assert_rst_min_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_rst) |-> rst_run_q >= 16'd8);

    assert_speed_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(speed_sel) |-> done);

    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!phy_rst && !xcvr_cfg_req && !drain_req));

    assert_err_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_error) |-> (done && !phy_rst));

    assert_err_clear_on_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_error) |-> busy);

endmodule

bind rate_switch_seq rate_switch_seq_checker u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .drain_req    (drain_req),
    .xcvr_cfg_req (xcvr_cfg_req),
    .traffic_idle (traffic_idle),
    .phy_rst      (phy_rst),
    .speed_sel    (speed_sel),
    .busy         (busy),
    .done         (done),
    .cfg_error    (cfg_error)
);

// File: tb/rate_switch_seq_test.sv
`timescale 1ns/1ps
module rate_switch_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_req_valid = 1'b0;
    logic [2:0] reg_req_speed = 3'd0;
    logic       an_req_valid = 1'b0;
    logic [2:0] an_req_speed = 3'd0;
    logic       traffic_idle = 1'b1;
    logic       xcvr_cfg_ack = 1'b0;
    logic [7:0] rst_len = 8'd8;
    logic       drain_req, xcvr_cfg_req, phy_rst, busy, done, cfg_error;
    logic [1:0] xcvr_cfg_rate;
    logic [2:0] speed_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rate_switch_seq uut (
        .clk(clk), .rst_n(rst_n),
        .reg_req_valid(reg_req_valid), .reg_req_speed(reg_req_speed),
        .an_req_valid(an_req_valid), .an_req_speed(an_req_speed),
        .traffic_idle(traffic_idle), .xcvr_cfg_ack(xcvr_cfg_ack), .rst_len(rst_len),
        .drain_req(drain_req), .xcvr_cfg_req(xcvr_cfg_req), .xcvr_cfg_rate(xcvr_cfg_rate),
        .phy_rst(phy_rst), .speed_sel(speed_sel), .busy(busy), .done(done),
        .cfg_error(cfg_error)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // one-cycle request from the selected source(s)
    task automatic pulse_req(input bit use_reg, input logic [2:0] rs, input bit use_an, input logic [2:0] as);
        reg_req_valid = use_reg; reg_req_speed = rs;
        an_req_valid  = use_an;  an_req_speed  = as;
        @(negedge clk);
        reg_req_valid = 1'b0; an_req_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1 speed_sel", speed_sel, 2);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 drain_req", drain_req, 0);
        check("R1 cfg_req", xcvr_cfg_req, 0);
        check("R1 phy_rst", phy_rst, 0);
        check("R1 cfg_error", cfg_error, 0);
    endtask

    // in-group or same-speed: done next cycle, nothing else
    task automatic t_short(input string req, input bit use_reg, input logic [2:0] rs,
                           input bit use_an, input logic [2:0] as, input int exp_speed);
        pulse_req(use_reg, rs, use_an, as);
        check({req, " done"}, done, 1);
        check({req, " speed_sel"}, speed_sel, exp_speed);
        check({req, " drain"}, drain_req, 0);
        check({req, " cfg_req"}, xcvr_cfg_req, 0);
        check({req, " phy_rst"}, phy_rst, 0);
        @(negedge clk);
        check({req, " busy clear"}, busy, 0);
    endtask

    task automatic t_illegal();
        pulse_req(1'b1, 3'd6, 1'b0, 3'd0);
        check("R2 busy on code 6", busy, 0);
        pulse_req(1'b0, 3'd0, 1'b1, 3'd7);
        check("R2 busy on code 7", busy, 0);
        check("R2 speed kept", speed_sel, 0);
    endtask

    // cross-group sequence with a cooperative acknowledge
    task automatic t_cross(input logic [2:0] tgt, input int grp, input int idle_wait,
                           input int ack_wait, input int len_in, input int exp_len,
                           input logic [2:0] stray);
        int rst_cnt = 0;
        bit saw_done = 1'b0;
        bit saw_req = 1'b0;
        rst_len = 8'(len_in);
        traffic_idle = (idle_wait == 0);
        pulse_req(1'b1, tgt, 1'b0, 3'd0);
        check("R6 drain raised", drain_req, 1);
        check("R10 busy raised", busy, 1);
        for (int i = 0; i < idle_wait; i++) begin
            check("R6 no cfg while traffic", xcvr_cfg_req, 0);
            if (i == 1) begin
                pulse_req(1'b1, stray, 1'b1, stray); // R10: ignored while busy
            end else begin
                @(negedge clk);
            end
        end
        traffic_idle = 1'b1;
        for (int i = 0; i < 4 && !saw_req; i++) begin
            @(negedge clk);
            if (xcvr_cfg_req) begin
                saw_req = 1'b1;
                check("R7 cfg rate", xcvr_cfg_rate, grp);
            end
        end
        check("R7 cfg request seen", saw_req, 1);
        for (int i = 0; i < ack_wait; i++) begin
            @(negedge clk);
            check("R7 cfg single pulse", xcvr_cfg_req, 0);
            check("R8 no reset before ack", phy_rst, 0);
        end
        xcvr_cfg_ack = 1'b1;
        @(negedge clk);
        xcvr_cfg_ack = 1'b0;
        for (int i = 0; i < 400 && !saw_done; i++) begin
            if (phy_rst) begin
                rst_cnt++;
                if (!drain_req) check("R8 drain during reset", drain_req, 1);
            end
            if (done) saw_done = 1'b1;
            else @(negedge clk);
        end
        check("R8 reset length", rst_cnt, exp_len);
        check("R9 done seen", saw_done, 1);
        check("R9 target applied", speed_sel, tgt);
        check("R9 drain released", drain_req, 0);
        check("R11 no error", cfg_error, 0);
        @(negedge clk);
        check("R10 busy clear", busy, 0);
        check("R10 stray request ignored", speed_sel, tgt);
    endtask

    // cross-group with no acknowledge
    task automatic t_timeout(input logic [2:0] tgt, input logic [2:0] prev);
        int wait_cnt = 0;
        int rst_seen = 0;
        bit in_wait = 1'b0;
        bit saw_done = 1'b0;
        traffic_idle = 1'b1;
        pulse_req(1'b1, tgt, 1'b0, 3'd0);
        for (int i = 0; i < 200 && !saw_done; i++) begin
            if (phy_rst) rst_seen++;
            if (done) saw_done = 1'b1;
            else begin
                if (in_wait) wait_cnt++;
                if (xcvr_cfg_req) in_wait = 1'b1;
                @(negedge clk);
            end
        end
        check("R11 done after timeout", saw_done, 1);
        check("R11 wait cycles", wait_cnt, 64);
        check("R11 error raised", cfg_error, 1);
        check("R11 no reset", rst_seen, 0);
        check("R11 speed unchanged", speed_sel, prev);
        @(negedge clk);
        check("R11 error held", cfg_error, 1);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_short("R3 same speed", 1'b1, 3'd2, 1'b0, 3'd0, 2);
        t_short("R4 reg in-group", 1'b1, 3'd1, 1'b0, 3'd0, 1);
        t_short("R5 an in-group", 1'b0, 3'd0, 1'b1, 3'd0, 0);
        t_short("R5 reg over an", 1'b1, 3'd2, 1'b1, 3'd1, 2);
        t_short("R4 back to 10M", 1'b1, 3'd0, 1'b0, 3'd0, 0);
        t_illegal();
        t_cross(3'd4, 2, 5, 3, 3, 8, 3'd1);
        t_cross(3'd3, 1, 3, 7, 20, 20, 3'd4);
        t_timeout(3'd2, 3);
        // R11: next accepted request clears the error
        pulse_req(1'b1, 3'd3, 1'b0, 3'd0);
        check("R11 error cleared", cfg_error, 0);
        check("R3 same speed done", done, 1);
        @(negedge clk);
        finished = 1'b1;
        finish_run();
    end

endmodule